// File: doc/BRIEF.md
# Three-Segment Gamma Curve Evaluator

This block evaluates one colour channel of a gamma curve for a stream of pixels. Each input is an unsigned code where 2^18 stands for full scale. Below full scale the curve is described by three stored segments that cover ranges nested inside one another. The narrowest segment has the finest step and serves the darkest codes. The widest has the coarsest step and reaches full scale. For every code the block picks the finest segment whose range holds the code. It reads the two neighbouring table points from an external segment memory and blends them linearly by the remainder bits of the code. Codes at or above full scale bypass the tables and return a programmed peak value.

Pixels enter on a valid/ready handshake and leave on a valid/ready handshake. The memory is read through a two-address read port with one cycle of latency. Loading the tables is done elsewhere. The pipeline accepts one pixel per cycle and holds every stage while the output is stalled.

Top module: `gamma_seg_eval`

## Requirements
- R1: Segment choice per accepted code c (below 2^18): c < 8 reads the darkest segment (rd_seg = 0) at lower address c; 8 <= c < 2048 reads the middle segment (rd_seg = 1) at lower address c >> 3; 2048 <= c reads the wide segment (rd_seg = 2) at lower address c >> 10. The upper address is always the lower address plus one.
- R2: With lower point a and upper point b, the result is a + floor((b - a) * f / 2^k). Here f is the low k bits of the code, and k is 0, 3 or 10 for segments 0, 1 and 2. A code in segment 0 therefore returns its table point unblended.
- R3: When b < a the blend rounds toward minus infinity, so the result lies between b and a.
- R4: Code 0 returns point 0 of the darkest segment exactly.
- R5: Any code of 2^18 or more, whatever its upper bits, returns peak_val as sampled in the cycle the pixel is accepted. Later changes of peak_val do not affect it.
- R6: With out_ready held high, a pixel accepted at a clock edge appears on out_valid/out_pix after the third following edge, and one pixel is accepted every cycle.
- R7: While out_valid is high and out_ready is low, out_pix stays unchanged, out_valid stays high and in_ready is low. No pixel is lost or duplicated across the stall.
- R8: After reset out_valid is low and in_ready is high.
- R9: The memory returns rd_data_lo/rd_data_hi on the edge after rd_en is high and must keep them unchanged while rd_en is low. Results stay correct across stalls under this contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel code offered |
| in_ready | output | 1 | Pixel code taken at this edge when valid |
| pix_code | input | 24 | Unsigned input code, full scale 2^18 |
| peak_val | input | 16 | Result for codes at or above full scale |
| rd_en | output | 1 | Segment memory read strobe |
| rd_seg | output | 2 | Segment select: 0 darkest, 1 middle, 2 wide |
| rd_addr_lo | output | 9 | Address of the lower point |
| rd_addr_hi | output | 9 | Address of the upper point |
| rd_data_lo | input | 16 | Lower point, one cycle after rd_en |
| rd_data_hi | input | 16 | Upper point, one cycle after rd_en |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken at this edge when valid |
| out_pix | output | 16 | Evaluated 16-bit result |

## Verification
The bench uses the package defaults: 3 fraction bits in the middle segment, 10 in the wide one, and 8 index bits. That gives 257-point tables and an 18-bit code space. With these values every segment boundary is within direct reach: 7/8, 2047/2048 and 262143/262144. The bench also drives the largest 24-bit code and walks both blended segments through table points whose slope turns negative. The small latency and the short stall window let the bench count hold cycles and edge-exact latency directly.

// File: rtl/gm_pkg.sv
package gm_pkg;

    localparam int GM_IN_W      = 24;
    localparam int GM_OUT_W     = 16;
    localparam int GM_FINE_SH   = 3;
    localparam int GM_COARSE_SH = 10;
    localparam int GM_IDX_W     = 8;

    localparam int GM_CODE_W    = GM_COARSE_SH + GM_IDX_W;
    localparam int GM_MID_W     = GM_FINE_SH + GM_IDX_W;
    localparam int GM_ADDR_W    = GM_IDX_W + 1;
    localparam int GM_FRAC_W    = GM_COARSE_SH;
    localparam int GM_PROD_W    = GM_OUT_W + GM_FRAC_W + 2;

    typedef enum logic [1:0] {
        SEG_DARK = 2'd0,
        SEG_MID  = 2'd1,
        SEG_WIDE = 2'd2
    } seg_e;

    typedef struct packed {
        logic                  full;
        logic [GM_OUT_W-1:0]   peak;
        logic [GM_FRAC_W-1:0]  frac;
    } meta_t;

    typedef struct packed {
        meta_t                 m;
        seg_e                  seg;
        logic [GM_ADDR_W-1:0]  addr;
    } lookup_t;

    typedef struct packed {
        logic                  full;
        logic [GM_OUT_W-1:0]   peak;
        logic [GM_OUT_W-1:0]   base;
        logic [GM_PROD_W-1:0]  prod;
    } blend_t;

    function automatic logic [GM_OUT_W-1:0] gm_clamp(input logic [GM_PROD_W-1:0] v);
        if (v[GM_PROD_W-1])
            return '0;
        else if (|v[GM_PROD_W-2:GM_OUT_W])
            return '1;
        else
            return v[GM_OUT_W-1:0];
    endfunction

endpackage

// File: rtl/gm_decode.sv
module gm_decode
    import gm_pkg::*;
(
    input  logic [GM_IN_W-1:0]  code,
    input  logic [GM_OUT_W-1:0] peak,
    output lookup_t             lk
);
    always_comb begin
        lk.m.peak = peak;
        lk.m.full = |code[GM_IN_W-1:GM_CODE_W];
        if (lk.m.full) begin
            lk.seg    = SEG_DARK;
            lk.addr   = '0;
            lk.m.frac = '0;
        end else if (|code[GM_CODE_W-1:GM_MID_W]) begin
            lk.seg    = SEG_WIDE;
            lk.addr   = GM_ADDR_W'(code[GM_CODE_W-1:GM_COARSE_SH]);
            lk.m.frac = code[GM_COARSE_SH-1:0];
        end else if (|code[GM_MID_W-1:GM_FINE_SH]) begin
            lk.seg    = SEG_MID;
            lk.addr   = GM_ADDR_W'(code[GM_MID_W-1:GM_FINE_SH]);
            lk.m.frac = {code[GM_FINE_SH-1:0], {(GM_COARSE_SH-GM_FINE_SH){1'b0}}};
        end else begin
            lk.seg    = SEG_DARK;
            lk.addr   = GM_ADDR_W'(code[GM_FINE_SH-1:0]);
            lk.m.frac = '0;
        end
    end
endmodule

// File: rtl/gm_blend.sv
module gm_blend
    import gm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                v_in,
    input  meta_t               meta,
    input  logic [GM_OUT_W-1:0] pt_lo,
    input  logic [GM_OUT_W-1:0] pt_hi,
    output logic                v_out,
    output logic [GM_OUT_W-1:0] pix
);
    logic signed [GM_OUT_W:0]    diff;
    logic signed [GM_PROD_W-1:0] diff_x, frac_x, prod_n;
    logic signed [GM_PROD_W-1:0] base_x, step_x, sum;
    blend_t                      b_q;
    logic                        v3;

    always_comb begin
        diff   = $signed({1'b0, pt_hi}) - $signed({1'b0, pt_lo});
        diff_x = GM_PROD_W'(diff);
        frac_x = GM_PROD_W'($signed({1'b0, meta.frac}));
        prod_n = diff_x * frac_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v3  <= 1'b0;
            b_q <= '0;
        end else if (en) begin
            v3       <= v_in;
            b_q.full <= meta.full;
            b_q.peak <= meta.peak;
            b_q.base <= pt_lo;
            b_q.prod <= prod_n;
        end
    end

    always_comb begin
        base_x = $signed(GM_PROD_W'({1'b0, b_q.base}));
        step_x = $signed(b_q.prod) >>> GM_FRAC_W;
        sum    = base_x + step_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            pix   <= '0;
        end else if (en) begin
            v_out <= v3;
            pix   <= b_q.full ? b_q.peak : gm_clamp(sum);
        end
    end

    // R5: a full-scale pixel leaves with the peak value it carried
    a_r5_peak_bypass: assert property (@(posedge clk) disable iff (rst)
        (en && v3 && b_q.full) |=> (v_out && pix == $past(b_q.peak)));
endmodule

// File: rtl/gamma_seg_eval.sv
module gamma_seg_eval
    import gm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [GM_IN_W-1:0]   pix_code,
    input  logic [GM_OUT_W-1:0]  peak_val,
    output logic                 rd_en,
    output logic [1:0]           rd_seg,
    output logic [GM_ADDR_W-1:0] rd_addr_lo,
    output logic [GM_ADDR_W-1:0] rd_addr_hi,
    input  logic [GM_OUT_W-1:0]  rd_data_lo,
    input  logic [GM_OUT_W-1:0]  rd_data_hi,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [GM_OUT_W-1:0]  out_pix
);
    logic    en;
    lookup_t dec;
    lookup_t s1_q;
    logic    s1_v;
    meta_t   s2_q;
    logic    s2_v;

    assign en       = !out_valid || out_ready;
    assign in_ready = en;

    gm_decode u_decode (
        .code (pix_code),
        .peak (peak_val),
        .lk   (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_q <= '0;
        end else if (en) begin
            s1_v <= in_valid;
            if (in_valid)
                s1_q <= dec;
        end
    end

    assign rd_en      = en && s1_v;
    assign rd_seg     = s1_q.seg;
    assign rd_addr_lo = s1_q.addr;
    assign rd_addr_hi = s1_q.addr + GM_ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v <= 1'b0;
            s2_q <= '0;
        end else if (en) begin
            s2_v <= s1_v;
            s2_q <= s1_q.m;
        end
    end

    gm_blend u_blend (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .v_in  (s2_v),
        .meta  (s2_q),
        .pt_lo (rd_data_lo),
        .pt_hi (rd_data_hi),
        .v_out (out_valid),
        .pix   (out_pix)
    );

    // R1: darkest segment never reads past its last point
    a_r1_dark_range: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_seg == 2'd0) |-> (rd_addr_hi <= GM_ADDR_W'(8)));
    // R1: middle segment is used only above the darkest range
    a_r1_mid_floor: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_seg == 2'd1) |-> (rd_addr_lo != '0));
    // R1: wide segment is used only above the middle range
    a_r1_wide_floor: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_seg == 2'd2) |-> (rd_addr_lo >= GM_ADDR_W'(2)));
    // R7: a stalled result is held
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
    // R9: no read is issued while the output is stalled
    a_r9_no_read_in_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !rd_en);
endmodule

// File: tb/gamma_seg_eval_bench.sv
module gamma_seg_eval_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] pix_code = '0;
    logic [15:0] peak_val = 16'h0;
    logic        rd_en;
    logic [1:0]  rd_seg;
    logic [8:0]  rd_addr_lo, rd_addr_hi;
    logic [15:0] rd_data_lo = '0, rd_data_hi = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_pix;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit lat_mode = 0;
    int    exp_q[$];
    string tag_q[$];
    int    acc_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gamma_seg_eval u_gamma_seg_eval (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .pix_code(pix_code), .peak_val(peak_val), .rd_en(rd_en), .rd_seg(rd_seg),
        .rd_addr_lo(rd_addr_lo), .rd_addr_hi(rd_addr_hi),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    function automatic int dark_pt(int i); return 100 + 50 * i; endfunction
    function automatic int mid_pt(int i);  return 1000 + (i * i * 7) % 20000; endfunction
    function automatic int wide_pt(int i); return (i * i * 97 + 13 * i) % 65536; endfunction

    function automatic int table_pt(int seg, int a);
        if (seg == 0 && a <= 8)   return dark_pt(a);
        if (seg == 1 && a <= 256) return mid_pt(a);
        if (seg == 2 && a <= 256) return wide_pt(a);
        return 16'hDEAD;
    endfunction

    // segment memory model: one cycle latency, holds while rd_en is low (R9)
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data_lo <= 16'(table_pt(int'(rd_seg), int'(rd_addr_lo)));
            rd_data_hi <= 16'(table_pt(int'(rd_seg), int'(rd_addr_hi)));
        end
    end

    function automatic int model(int x, int peak);
        int a, b, f;
        if (x >= 262144) return peak;
        if (x < 8) return dark_pt(x);
        if (x < 2048) begin
            a = mid_pt(x >> 3); b = mid_pt((x >> 3) + 1); f = x & 7;
            return a + (((b - a) * f) >>> 3);
        end
        a = wide_pt(x >> 10); b = wide_pt((x >> 10) + 1); f = x & 1023;
        return a + (((b - a) * f) >>> 10);
    endfunction

    function automatic string tag_of(int x);
        int a, b;
        if (x >= 262144) return "R5";
        if (x == 0) return "R4";
        if (x < 8) return "R1";
        if (x < 2048) begin a = mid_pt(x >> 3); b = mid_pt((x >> 3) + 1); end
        else begin a = wide_pt(x >> 10); b = wide_pt((x >> 10) + 1); end
        return (b < a) ? "R3" : "R2";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard, sampled between edges
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected output", 1, 0);
                end else begin
                    check(tag_q[0], int'(out_pix), exp_q[0]);
                    if (lat_mode) check("R6 latency", cyc - acc_q[0], 4);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                    void'(acc_q.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model(int'(pix_code), int'(peak_val)));
                tag_q.push_back(tag_of(int'(pix_code)));
                acc_q.push_back(cyc);
            end
        end
    end

    task automatic send(int code);
        @(negedge clk);
        in_valid = 1'b1;
        pix_code = 24'(code);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        check("R7 all outputs delivered", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        #1;
        check("R8 out_valid after reset", int'(out_valid), 0);
        check("R8 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_dark();
        send(0);
        for (int c = 1; c < 8; c++) send(c);
        idle_in();
        drain();
    endtask

    task automatic t_mid();
        int codes[8] = '{8, 9, 15, 100, 333, 1027, 2040, 2047};
        foreach (codes[i]) send(codes[i]);
        for (int c = 16; c < 2048; c += 61) send(c);
        idle_in();
        drain();
    endtask

    task automatic t_wide();
        int codes[6] = '{2048, 2049, 3071, 5000, 262143, 261120};
        foreach (codes[i]) send(codes[i]);
        for (int c = 2100; c < 262144; c += 9973) send(c);
        idle_in();
        drain();
    endtask

    task automatic t_full();
        peak_val = 16'hBEEF;
        send(262144);
        peak_val = 16'h1234;
        send(24'hFFFFFF);
        peak_val = 16'h0042;
        send(24'h800000);
        @(negedge clk);
        in_valid = 1'b0;
        peak_val = 16'hFFFF;
        drain();
    endtask

    task automatic t_stream();
        lat_mode = 1;
        for (int i = 0; i < 10; i++) send(3 + i * 997);
        idle_in();
        drain();
        lat_mode = 0;
    endtask

    task automatic t_stall();
        logic [15:0] held;
        @(negedge clk);
        out_ready = 1'b0;
        send(5);
        send(77);
        send(4095);
        send(150000);
        idle_in();
        #1;
        check("R7 valid under stall", int'(out_valid), 1);
        held = out_pix;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            check("R7 valid held", int'(out_valid), 1);
            check("R7 in_ready low", int'(in_ready), 0);
            check("R7 value held", int'(out_pix), int'(held));
        end
        @(negedge clk);
        out_ready = 1'b1;
        drain();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dark();
        t_mid();
        t_wide();
        t_full();
        t_stream();
        t_stall();
        t_dark();
        finish_run();
    end
endmodule